// File: doc/BRIEF.md
# Reset Source Controller with Cause Register

This block collects the reset requests of a mixed-signal companion die and turns them into two reset outputs. Power-on, an external pull on the shared reset pin, a watchdog timeout or a wrong watchdog service, an over-temperature pulse and a main-supply low-voltage pulse are its five reset sources. Its outputs are a global reset for the register bank of a serial-interface peripheral and a low drive for the bidirectional, open-drain reset pin. Temperature and voltage detection sit outside the block, and their events arrive as single-cycle digital pulses.

After power-on, and after any internally generated reset, the pin is held low. The hold ends once the supply-good signal has been high for `TRST` consecutive clock cycles. An 8-bit sticky cause register records which sources have fired since software last cleared it. The same register holds two wake-up origin flags, one for bus activity and one for the wake-up pin. Software reads the register through a simple address/data port and clears any bit by writing a one to it.

Power-on is the asynchronous `rst_ni`. It leaves only the power-on flag set. Every other reset source leaves the cause register intact, because the cause register does not sit behind the peripheral reset it produces.

Top module: `rst_src_ctrl`

## Requirements
- R1: While `rst_ni` is low, the cause register reads 0x80 (only bit 7, the power-on flag, set), `pin_drive_low_o` is 1 and `periph_rst_o` is 1.
- R2: The pin hold ends, and `pin_drive_low_o` returns to 0, once `vdd_good_i` has been sampled high on `TRST` consecutive clock edges during the hold. Any edge that samples `vdd_good_i` low restarts the count.
- R3: A pulse on `wdog_timeout_i` or on `wdog_bad_svc_i` sets bit 5 of the cause register and starts a pin hold. The other flags are left unchanged.
- R4: A pulse on `lv_evt_i` sets bit 3 and starts a pin hold.
- R5: A pulse on `hot_evt_i` always sets bit 4. It starts a pin hold only when `hot_rst_dis_i` is 0.
- R6: A sensed low on `pin_low_i` while the block is not driving the pin sets bit 6 and does not start a hold. A sensed low while the block drives the pin leaves bit 6 unchanged.
- R7: A pulse on `bus_wake_i` sets bit 1, and a pulse on `pin_wake_i` sets bit 0.
- R8: A write at address 0x0D clears every cause bit whose `reg_wdata_i` bit is 1 and leaves the bits written 0 unchanged. This includes bit 7. A write at any other address has no effect. Bit 2 always reads 0.
- R9: When a hardware set and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R10: `reg_rdata_o` shows the cause register when `reg_addr_i` is 0x0D and shows 0 for any other address.
- R11: `periph_rst_o` is 1 whenever the pin is driven low by the block or sensed low, and 0 otherwise.
- R12: A new internal reset request during a hold restarts the `TRST` count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| vdd_good_i | input | 1 | Supply reported good |
| pin_low_i | input | 1 | Synchronized sensed level of the reset pin, 1 = low |
| wdog_timeout_i | input | 1 | Watchdog timeout pulse |
| wdog_bad_svc_i | input | 1 | Wrong watchdog service pulse |
| hot_evt_i | input | 1 | Over-temperature pulse |
| hot_rst_dis_i | input | 1 | Mask bit: 1 blocks the over-temperature reset |
| lv_evt_i | input | 1 | Main-supply low-voltage pulse |
| bus_wake_i | input | 1 | Wake-up by bus activity pulse |
| pin_wake_i | input | 1 | Wake-up by wake pin pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data, 1 = clear bit |
| reg_rdata_o | output | 8 | Read data |
| periph_rst_o | output | 1 | Global reset for peripheral registers |
| pin_drive_low_o | output | 1 | Pull the reset pin low |

## Verification
The bench checks the hold length under three supply patterns: supply good from the start, supply late after release, and supply dropping partway through a hold. Together these separate a count of consecutive good cycles from a count of total cycles. The bench fires each reset source alone, so that a wrong bit position or a missing hold shows up. It also drives the external pin both while the block is idle and while the block is driving it, which shows whether the block flags its own drive. Write-one-to-clear is tried with zero data, with another address, and together with a set on the same bit. Masked and unmasked over-temperature events are included. A long constrained-random stream then mixes all the inputs against a cycle model.

// File: rtl/rst_src_pkg.sv
package rst_src_pkg;
  localparam int unsigned CAUSE_W  = 8;
  localparam int unsigned BIT_POR  = 7;
  localparam int unsigned BIT_EXT  = 6;
  localparam int unsigned BIT_WDG  = 5;
  localparam int unsigned BIT_HOT  = 4;
  localparam int unsigned BIT_LVR  = 3;
  localparam int unsigned BIT_RSV  = 2;
  localparam int unsigned BIT_BUSW = 1;
  localparam int unsigned BIT_PINW = 0;

  typedef logic [CAUSE_W-1:0] cause_t;

  localparam cause_t CAUSE_AT_POR = cause_t'(1 << BIT_POR);
  localparam cause_t CAUSE_LIVE   = ~cause_t'(1 << BIT_RSV);
endpackage

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int unsigned TRST = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  input  logic vdd_good_i,
  output logic hold_o
);
  localparam int unsigned CNT_W = (TRST > 1) ? $clog2(TRST) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TRST - 1);

  logic             hold_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (trig_i) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q) begin
      if (!vdd_good_i) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign hold_o = hold_q;

  a_r12_trig_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (hold_q && cnt_q == '0));
  a_r2_bad_supply_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !trig_i && !vdd_good_i) |=> (hold_q && cnt_q == '0));
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_LAST);
  a_r2_idle_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_q && !trig_i) |=> !hold_q);
endmodule

// File: rtl/rst_cause_reg.sv
module rst_cause_reg
  import rst_src_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 5,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h0D)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cause_t            set_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  cause_t            wdata_i,
  output cause_t            rdata_o
);
  cause_t cause_q;
  cause_t clr_mask;
  logic   hit;

  assign hit      = (addr_i == REG_ADDR);
  assign clr_mask = (wr_i && hit) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cause_q <= CAUSE_AT_POR;
    else         cause_q <= ((cause_q & ~clr_mask) | set_i) & CAUSE_LIVE;
  end

  assign rdata_o = hit ? cause_q : '0;

  a_r9_set_dominates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & CAUSE_LIVE)) |=> ((cause_q & $past(set_i & CAUSE_LIVE)) == $past(set_i & CAUSE_LIVE)));
  a_r8_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && hit) |=> ((cause_q & $past(wdata_i & ~set_i)) == '0));
  a_r8_quiet_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_i && hit) && set_i == '0) |=> $stable(cause_q));
  a_r8_rsv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cause_q[BIT_RSV]);
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
  import rst_src_pkg::*;
#(
  parameter int unsigned       TRST     = 64,
  parameter int unsigned       ADDR_W   = 5,
  parameter logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(8'h0D)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vdd_good_i,
  input  logic              pin_low_i,
  input  logic              wdog_timeout_i,
  input  logic              wdog_bad_svc_i,
  input  logic              hot_evt_i,
  input  logic              hot_rst_dis_i,
  input  logic              lv_evt_i,
  input  logic              bus_wake_i,
  input  logic              pin_wake_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  output logic              periph_rst_o,
  output logic              pin_drive_low_o
);
  logic   hold;
  logic   int_trig;
  cause_t cause_set;

  // masked over-temperature still records, only the reset is blocked
  assign int_trig = wdog_timeout_i | wdog_bad_svc_i | lv_evt_i |
                    (hot_evt_i & ~hot_rst_dis_i);

  always_comb begin
    cause_set           = '0;
    cause_set[BIT_EXT]  = pin_low_i & ~hold;
    cause_set[BIT_WDG]  = wdog_timeout_i | wdog_bad_svc_i;
    cause_set[BIT_HOT]  = hot_evt_i;
    cause_set[BIT_LVR]  = lv_evt_i;
    cause_set[BIT_BUSW] = bus_wake_i;
    cause_set[BIT_PINW] = pin_wake_i;
  end

  rst_hold_timer #(.TRST(TRST)) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .trig_i     (int_trig),
    .vdd_good_i (vdd_good_i),
    .hold_o     (hold)
  );

  rst_cause_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_cause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (cause_set),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o)
  );

  assign pin_drive_low_o = hold;
  assign periph_rst_o    = hold | pin_low_i;

  a_r11_periph_covers_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_drive_low_o |-> periph_rst_o);
  a_r5_masked_hot_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_evt_i && hot_rst_dis_i && !wdog_timeout_i && !wdog_bad_svc_i && !lv_evt_i && !pin_drive_low_o)
      |=> !pin_drive_low_o);
  a_r6_ext_no_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_low_i && !pin_drive_low_o && !int_trig) |=> !pin_drive_low_o);
endmodule

// File: tb/rst_src_ctrl_tb_top.sv
module rst_src_ctrl_tb_top;
  localparam int unsigned TRST = 12;
  localparam int unsigned AW   = 5;
  localparam logic [AW-1:0] RA = 5'h0D;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, vdd, ext_pull, pin_low;
  logic wd_to, wd_bad, hot, hot_dis, lv, busw, pinw, wr;
  logic [AW-1:0] addr;
  logic [7:0] wdata, rdata;
  logic periph, drv;

  assign pin_low = drv | ext_pull;

  rst_src_ctrl #(.TRST(TRST), .ADDR_W(AW), .REG_ADDR(RA)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .vdd_good_i(vdd), .pin_low_i(pin_low),
    .wdog_timeout_i(wd_to), .wdog_bad_svc_i(wd_bad), .hot_evt_i(hot),
    .hot_rst_dis_i(hot_dis), .lv_evt_i(lv), .bus_wake_i(busw), .pin_wake_i(pinw),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .periph_rst_o(periph), .pin_drive_low_o(drv)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] m_cause;
  logic m_hold;
  int m_cnt;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    return (addr == RA) ? m_cause : 8'h00;
  endfunction

  task automatic model_edge();
    logic trig;
    logic [7:0] set, clr;
    trig = wd_to | wd_bad | lv | (hot & ~hot_dis);
    set  = {1'b0, ext_pull & ~m_hold, wd_to | wd_bad, hot, lv, 1'b0, busw, pinw};
    clr  = (wr && addr == RA) ? wdata : 8'h00;
    m_cause = ((m_cause & ~clr) | set) & 8'hFB;
    if (trig) begin
      m_hold = 1'b1; m_cnt = 0;
    end else if (m_hold) begin
      if (!vdd) m_cnt = 0;
      else if (m_cnt == TRST - 1) begin m_hold = 1'b0; m_cnt = 0; end
      else m_cnt++;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2 pin drive", {7'd0, drv}, {7'd0, m_hold});
    chk("R11 periph rst", {7'd0, periph}, {7'd0, m_hold | ext_pull});
    chk("R10 read data", rdata, exp_rd());
    wd_to = 0; wd_bad = 0; hot = 0; lv = 0; busw = 0; pinw = 0; wr = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4 * TRST && m_hold; i++) tick();
  endtask

  task automatic clear_all();
    wr = 1; addr = RA; wdata = 8'hFF; tick();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 0; vdd = 0; ext_pull = 0; wd_to = 0; wd_bad = 0; hot = 0; hot_dis = 0;
    lv = 0; busw = 0; pinw = 0; wr = 0; addr = RA; wdata = 0;
    #9;
    @(negedge clk);
    chk("R1 cause at por", rdata, 8'h80);
    chk("R1 pin at por", {7'd0, drv}, 8'd1);
    chk("R1 periph at por", {7'd0, periph}, 8'd1);
    m_cause = 8'h80; m_hold = 1; m_cnt = 0;
    rst_n = 1;

    // R2: late supply, then a drop mid-count
    repeat (5) tick();
    chk("R2 held while supply bad", {7'd0, drv}, 8'd1);
    vdd = 1;
    repeat (5) tick();
    vdd = 0; tick(); vdd = 1;
    repeat (TRST - 1) tick();
    chk("R2 still held before full count", {7'd0, drv}, 8'd1);
    tick();
    chk("R2 released after TRST good", {7'd0, drv}, 8'd0);

    // R8: clear por bit
    wr = 1; wdata = 8'h80; tick();
    chk("R8 por cleared", rdata, 8'h00);

    // R3 watchdog timeout and bad service
    wd_to = 1; tick();
    chk("R3 wdg flag", rdata, 8'h20);
    chk("R3 hold started", {7'd0, drv}, 8'd1);
    wait_idle(); clear_all();
    wd_bad = 1; tick();
    chk("R3 bad service flag", rdata, 8'h20);
    wait_idle();

    // R4 low voltage, keeps wdg flag
    lv = 1; tick();
    chk("R4 lv flag, wdg kept", rdata, 8'h28);
    chk("R4 hold started", {7'd0, drv}, 8'd1);
    wait_idle(); clear_all();

    // R5 masked and unmasked hot
    hot_dis = 1; hot = 1; tick();
    chk("R5 masked hot flag", rdata, 8'h10);
    chk("R5 masked hot no hold", {7'd0, drv}, 8'd0);
    hot_dis = 0; hot = 1; tick();
    chk("R5 unmasked hot hold", {7'd0, drv}, 8'd1);
    wait_idle(); clear_all();

    // R6 external pin while idle and while driving
    ext_pull = 1; repeat (3) tick();
    chk("R6 ext flag", rdata, 8'h40);
    chk("R6 ext no hold", {7'd0, drv}, 8'd0);
    chk("R6 ext periph", {7'd0, periph}, 8'd1);
    ext_pull = 0; tick(); clear_all();
    lv = 1; tick();
    ext_pull = 1; repeat (3) tick(); ext_pull = 0;
    chk("R6 own drive not flagged", rdata & 8'h40, 8'h00);
    wait_idle(); clear_all();

    // R7 wake flags
    busw = 1; tick();
    chk("R7 bus wake", rdata, 8'h02);
    pinw = 1; tick();
    chk("R7 pin wake", rdata, 8'h03);

    // R8 zero write, other address; R10 other address reads 0
    wr = 1; wdata = 8'h00; tick();
    chk("R8 zero write keeps", rdata, 8'h03);
    wr = 1; addr = 5'h0C; wdata = 8'hFF; tick();
    chk("R10 other addr reads 0", rdata, 8'h00);
    addr = RA; tick();
    chk("R8 other addr no clear", rdata, 8'h03);
    wr = 1; wdata = 8'h01; tick();
    chk("R8 partial clear", rdata, 8'h02);

    // R9 set beats clear
    clear_all();
    wd_to = 1; wr = 1; wdata = 8'h20; tick();
    chk("R9 set wins", rdata, 8'h20);
    wait_idle();

    // R12 retrigger during hold
    lv = 1; tick();
    repeat (5) tick();
    wd_to = 1; tick();
    repeat (TRST - 1) tick();
    chk("R12 held after retrigger", {7'd0, drv}, 8'd1);
    tick();
    chk("R12 released TRST after retrigger", {7'd0, drv}, 8'd0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      vdd      = ($urandom_range(0, 19) != 0);
      ext_pull = ($urandom_range(0, 29) == 0);
      wd_to    = ($urandom_range(0, 59) == 0);
      wd_bad   = ($urandom_range(0, 79) == 0);
      hot      = ($urandom_range(0, 49) == 0);
      hot_dis  = ($urandom_range(0, 1) == 0);
      lv       = ($urandom_range(0, 69) == 0);
      busw     = ($urandom_range(0, 29) == 0);
      pinw     = ($urandom_range(0, 29) == 0);
      wr       = ($urandom_range(0, 7) == 0);
      wdata    = 8'($urandom);
      addr     = ($urandom_range(0, 5) == 0) ? 5'($urandom) : RA;
      tick();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule